// File: doc/BRIEF.md
# Regulator Fault Supervisor

This block watches a switching regulator from the digital side. On every sampling tick it takes the digitized output voltage and output current. It compares them with limits that are programmed relative to the commanded voltage, which can change. If an overvoltage, undervoltage, overcurrent or bad-slew condition lasts long enough, the block latches a sticky fault flag. In the same clock edge it moves its regulator state machine into shutdown.

The state machine has four states: idle while the chip is disabled, transitioning while the output ramps to a new command, regulating once the output sits inside the tolerance band, and shutdown after a fault. Overshoot and droop limits are enforced only while regulating. The slew window is enforced only while transitioning. The current limit applies in both active states. Deasserting the enable input clears every flag and returns the block to idle. Faults can be cleared in no other way.

Top module: `reg_fault_mon`

## Requirements
- R1: While regulating with no command change in the same cycle, a tick on which `vout_code > vcmd_code + ov_margin` counts toward the overvoltage fault (`ov_flag`).
- R2: While regulating with no command change in the same cycle, a tick on which `vout_code + uv_margin < vcmd_code` counts toward the undervoltage fault (`uv_flag`).
- R3: While regulating or transitioning, a tick on which `iout_code > oc_limit` counts toward the overcurrent fault (`oc_flag`).
- R4: Each fault latches on the tick that completes N consecutive qualifying ticks, where N is its response count, and a count of 0 acts as 1. A tick without the condition restarts the count. Cycles without a tick leave the count unchanged.
- R5: A fault moves the state to shutdown on the same clock edge that sets its flag, from regulating or from transitioning. Flags and shutdown then hold while `enable` stays high. A cycle with `enable` low clears all flags and returns to idle at the next edge.
- R6: Any change of `vcmd_code` while regulating or transitioning (with no fault on that edge) puts the block in transitioning. A transitioning tick on which the voltage lies inside `[vcmd-uv_margin, vcmd+ov_margin]` moves it to regulating.
- R7: While transitioning, the block counts ticks that are out of band and carry no command change. Every SLEW_WIN such ticks, it takes |vout - reference|, where the reference is the voltage captured at the start of the window. If that value is below `slew_min` or above `slew_max`, `slew_flag` latches. The reference is re-captured on every command change and in every non-transitioning cycle.
- R8: After reset the block is idle, with all flags and all state outputs low. The first enabled cycle moves it from idle to transitioning.
- R9: Overshoot and droop conditions during transitioning never count toward a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Chip enable; low clears faults |
| tick | input | 1 | Sampling strobe |
| vout_code | input | VW | Digitized output voltage |
| iout_code | input | IW | Digitized output current |
| vcmd_code | input | VW | Commanded voltage |
| ov_margin | input | VW | Allowed overshoot above command |
| uv_margin | input | VW | Allowed droop below command |
| oc_limit | input | IW | Maximum output current |
| ov_resp | input | RW | Overvoltage response count in ticks |
| uv_resp | input | RW | Undervoltage response count in ticks |
| oc_resp | input | RW | Overcurrent response count in ticks |
| slew_min | input | VW | Minimum change per slew window |
| slew_max | input | VW | Maximum change per slew window |
| ov_flag | output | 1 | Overvoltage fault latched |
| uv_flag | output | 1 | Undervoltage fault latched |
| oc_flag | output | 1 | Overcurrent fault latched |
| slew_flag | output | 1 | Slew fault latched |
| in_reg | output | 1 | Regulating state |
| in_trans | output | 1 | Transitioning state |
| in_shut | output | 1 | Shutdown state |

## Verification
The bench first sends an overshoot that ends one tick before its response count and then one that lasts the full count. A design that did not restart the count would trip on the first, and one that counted clock cycles instead of ticks would trip early, because ticks come every other cycle. The bench also drives a large overshoot during a downward ramp. A design that checked the band in every active state would shut down there. A stalled output during an upward ramp checks that the slew window closes on the correct tick. A design with an off-by-one window, or one that never re-captured its reference, would latch `slew_flag` a tick early or late, or not at all. Re-enable after each fault shows whether flags really clear and whether shutdown is held until then.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REG   = 2'd1,
    ST_TRANS = 2'd2,
    ST_SHUT  = 2'd3
  } fm_state_e;
endpackage

// File: rtl/fm_persist.sv
module fm_persist #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic          cond,
  input  logic [RW-1:0] limit,
  output logic          trip,
  output logic          flag
);
  logic [RW-1:0] cnt_q, cnt_d;
  logic [RW:0]   cnt_inc;
  logic [RW-1:0] lim_eff;
  logic          flag_d;

  assign lim_eff = (limit == '0) ? RW'(1) : limit;
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign trip    = !clr && tick && cond && (cnt_inc >= {1'b0, lim_eff});

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag;
    if (clr) begin
      cnt_d  = '0;
      flag_d = 1'b0;
    end else begin
      if (tick) begin
        if (cond) cnt_d = cnt_inc[RW] ? cnt_q : cnt_inc[RW-1:0];
        else      cnt_d = '0;
      end
      if (trip) flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flag  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      flag  <= flag_d;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R5
  AST_TRIP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tick)); // R4
endmodule

// File: rtl/fm_slew.sv
module fm_slew #(
  parameter int VW  = 10,
  parameter int WIN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          restart,
  input  logic          run,
  input  logic [VW-1:0] vout,
  input  logic [VW-1:0] rate_min,
  input  logic [VW-1:0] rate_max,
  output logic          trip,
  output logic          flag
);
  localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN - 1);

  logic [VW-1:0] vref_q, vref_d;
  logic [CW-1:0] win_q, win_d;
  logic [VW-1:0] delta;
  logic          win_end;

  assign delta   = (vout >= vref_q) ? (vout - vref_q) : (vref_q - vout);
  assign win_end = run && !restart && (win_q == LAST);
  assign trip    = !clr && win_end && ((delta < rate_min) || (delta > rate_max));

  always_comb begin
    vref_d = vref_q;
    win_d  = win_q;
    if (restart) begin
      vref_d = vout;
      win_d  = '0;
    end else if (run) begin
      if (win_end) begin
        vref_d = vout;
        win_d  = '0;
      end else begin
        win_d  = win_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vref_q <= '0;
      win_q  <= '0;
      flag   <= 1'b0;
    end else begin
      vref_q <= vref_d;
      win_q  <= win_d;
      if (clr)       flag <= 1'b0;
      else if (trip) flag <= 1'b1;
    end
  end

  AST_SLEW_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(run)); // R7
endmodule

// File: rtl/fm_seq.sv
module fm_seq
  import fm_pkg::*;
#(
  parameter int VW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          tick,
  input  logic          in_band,
  input  logic          trip,
  input  logic [VW-1:0] vcmd,
  output logic          cmd_chg,
  output fm_state_e     state
);
  fm_state_e     state_d;
  logic [VW-1:0] cmd_q;

  assign cmd_chg = (vcmd != cmd_q);

  always_comb begin
    state_d = state;
    if (!enable) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:  state_d = ST_TRANS;
        ST_REG: begin
          if (trip)         state_d = ST_SHUT;
          else if (cmd_chg) state_d = ST_TRANS;
        end
        ST_TRANS: begin
          if (trip)                state_d = ST_SHUT;
          else if (cmd_chg)        state_d = ST_TRANS;
          else if (tick && in_band) state_d = ST_REG;
        end
        ST_SHUT:  state_d = ST_SHUT;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cmd_q <= '0;
    end else begin
      state <= state_d;
      cmd_q <= vcmd;
    end
  end

  AST_SHUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHUT && enable) |=> (state == ST_SHUT)); // R5
  AST_CMD_TO_TRANS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !trip && cmd_chg && (state == ST_REG || state == ST_TRANS))
      |=> (state == ST_TRANS)); // R6
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (state == ST_IDLE)); // R5
endmodule

// File: rtl/reg_fault_mon.sv
module reg_fault_mon
  import fm_pkg::*;
#(
  parameter int VW       = 10,
  parameter int IW       = 10,
  parameter int RW       = 8,
  parameter int SLEW_WIN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          tick,
  input  logic [VW-1:0] vout_code,
  input  logic [IW-1:0] iout_code,
  input  logic [VW-1:0] vcmd_code,
  input  logic [VW-1:0] ov_margin,
  input  logic [VW-1:0] uv_margin,
  input  logic [IW-1:0] oc_limit,
  input  logic [RW-1:0] ov_resp,
  input  logic [RW-1:0] uv_resp,
  input  logic [RW-1:0] oc_resp,
  input  logic [VW-1:0] slew_min,
  input  logic [VW-1:0] slew_max,
  output logic          ov_flag,
  output logic          uv_flag,
  output logic          oc_flag,
  output logic          slew_flag,
  output logic          in_reg,
  output logic          in_trans,
  output logic          in_shut
);
  fm_state_e state;
  logic      cmd_chg, in_band, trip_any;
  logic      ov_raw, uv_raw, oc_raw;
  logic      ov_cond, uv_cond, oc_cond;
  logic      ov_trip, uv_trip, oc_trip, sl_trip;
  logic      sl_run, sl_restart, clr;
  logic      active, regulating, ramping;
  logic [VW:0] v_hi, v_lo;

  assign clr        = !enable;
  assign regulating = (state == ST_REG);
  assign ramping    = (state == ST_TRANS);
  assign active     = regulating || ramping;

  assign v_hi    = {1'b0, vcmd_code} + {1'b0, ov_margin};
  assign v_lo    = {1'b0, vout_code} + {1'b0, uv_margin};
  assign ov_raw  = {1'b0, vout_code} > v_hi;
  assign uv_raw  = v_lo < {1'b0, vcmd_code};
  assign oc_raw  = iout_code > oc_limit;
  assign in_band = !ov_raw && !uv_raw;

  assign ov_cond = regulating && !cmd_chg && ov_raw;
  assign uv_cond = regulating && !cmd_chg && uv_raw;
  assign oc_cond = active && oc_raw;

  assign sl_restart = !ramping || cmd_chg;
  assign sl_run     = tick && ramping && !in_band;

  assign trip_any = ov_trip || uv_trip || oc_trip || sl_trip;

  fm_persist #(.RW(RW)) u_ov (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .cond(ov_cond),
    .limit(ov_resp), .trip(ov_trip), .flag(ov_flag));
  fm_persist #(.RW(RW)) u_uv (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .cond(uv_cond),
    .limit(uv_resp), .trip(uv_trip), .flag(uv_flag));
  fm_persist #(.RW(RW)) u_oc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .cond(oc_cond),
    .limit(oc_resp), .trip(oc_trip), .flag(oc_flag));

  fm_slew #(.VW(VW), .WIN(SLEW_WIN)) u_slew (
    .clk(clk), .rst_n(rst_n), .clr(clr), .restart(sl_restart), .run(sl_run),
    .vout(vout_code), .rate_min(slew_min), .rate_max(slew_max),
    .trip(sl_trip), .flag(slew_flag));

  fm_seq #(.VW(VW)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .in_band(in_band),
    .trip(trip_any), .vcmd(vcmd_code), .cmd_chg(cmd_chg), .state(state));

  assign in_reg   = regulating;
  assign in_trans = ramping;
  assign in_shut  = (state == ST_SHUT);

  AST_FAULT_SHUTS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ov_flag) || $rose(uv_flag) || $rose(oc_flag) || $rose(slew_flag))
      |-> in_shut); // R5
  AST_NO_BAND_IN_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (ramping && !ov_flag && !uv_flag && enable) |=> (!ov_flag && !uv_flag)); // R9
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !(ov_flag || uv_flag || oc_flag || slew_flag)); // R5
endmodule

// File: tb/sim_reg_fault_mon.sv
`timescale 1ns/1ps
module sim_reg_fault_mon;
  localparam int VW = 10, IW = 10, RW = 8, WIN = 4;

  logic clk = 1'b0;
  logic rst_n, enable, tick;
  logic [VW-1:0] vout_code, vcmd_code, ov_margin, uv_margin, slew_min, slew_max;
  logic [IW-1:0] iout_code, oc_limit;
  logic [RW-1:0] ov_resp, uv_resp, oc_resp;
  logic ov_flag, uv_flag, oc_flag, slew_flag, in_reg, in_trans, in_shut;

  int compared = 0, mismatched = 0, cyc = 0;
  int vtgt = 0, slope = 0;

  // reference model state: 0 idle, 1 regulate, 2 transition, 3 shutdown
  int m_st, m_cq, c_ov, c_uv, c_oc, m_win, m_vref;
  bit f_ov, f_uv, f_oc, f_sl;

  always #5 clk = ~clk;

  reg_fault_mon #(.VW(VW), .IW(IW), .RW(RW), .SLEW_WIN(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
    .vout_code(vout_code), .iout_code(iout_code), .vcmd_code(vcmd_code),
    .ov_margin(ov_margin), .uv_margin(uv_margin), .oc_limit(oc_limit),
    .ov_resp(ov_resp), .uv_resp(uv_resp), .oc_resp(oc_resp),
    .slew_min(slew_min), .slew_max(slew_max),
    .ov_flag(ov_flag), .uv_flag(uv_flag), .oc_flag(oc_flag), .slew_flag(slew_flag),
    .in_reg(in_reg), .in_trans(in_trans), .in_shut(in_shut));

  function automatic int eff(input int r);
    return (r == 0) ? 1 : r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cq = 0; c_ov = 0; c_uv = 0; c_oc = 0; m_win = 0; m_vref = 0;
      f_ov = 0; f_uv = 0; f_oc = 0; f_sl = 0;
    end else begin
      int v, vc, d;
      bit chg, ovr, uvr, band, t_ov, t_uv, t_oc, t_sl;
      v = vout_code; vc = vcmd_code;
      chg  = (vc != m_cq);
      ovr  = v > vc + ov_margin;
      uvr  = v + uv_margin < vc;
      band = !ovr && !uvr;
      t_ov = 0; t_uv = 0; t_oc = 0; t_sl = 0;
      if (!enable) begin
        m_st = 0; c_ov = 0; c_uv = 0; c_oc = 0;
        f_ov = 0; f_uv = 0; f_oc = 0; f_sl = 0;
        m_vref = v; m_win = 0;
      end else begin
        if (tick) begin
          if (m_st == 1 && !chg && ovr) begin c_ov++; t_ov = (c_ov >= eff(ov_resp)); end
          else c_ov = 0;
          if (m_st == 1 && !chg && uvr) begin c_uv++; t_uv = (c_uv >= eff(uv_resp)); end
          else c_uv = 0;
          if ((m_st == 1 || m_st == 2) && iout_code > oc_limit) begin
            c_oc++; t_oc = (c_oc >= eff(oc_resp));
          end else c_oc = 0;
        end
        if (m_st != 2 || chg) begin
          m_vref = v; m_win = 0;
        end else if (tick && !band) begin
          if (m_win == WIN - 1) begin
            d = (v > m_vref) ? v - m_vref : m_vref - v;
            t_sl = (d < slew_min) || (d > slew_max);
            m_vref = v; m_win = 0;
          end else m_win++;
        end
        f_ov |= t_ov; f_uv |= t_uv; f_oc |= t_oc; f_sl |= t_sl;
        case (m_st)
          0: m_st = 2;
          1: if (t_ov || t_uv || t_oc || t_sl) m_st = 3; else if (chg) m_st = 2;
          2: if (t_ov || t_uv || t_oc || t_sl) m_st = 3; else if (chg) m_st = 2;
             else if (tick && band) m_st = 1;
          default: m_st = 3;
        endcase
      end
      m_cq = vc;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1 ov_flag", ov_flag, f_ov);
    chk("R2 uv_flag", uv_flag, f_uv);
    chk("R3 oc_flag", oc_flag, f_oc);
    chk("R7 slew_flag", slew_flag, f_sl);
    chk("R6 in_reg", in_reg, m_st == 1);
    chk("R6 in_trans", in_trans, m_st == 2);
    chk("R5 in_shut", in_shut, m_st == 3);
  endtask

  // one cycle: compare at the falling edge, then drive the next inputs
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      compare_all();
      if (tick) begin
        if (vout_code < vtgt) vout_code = (vtgt - vout_code > slope) ? vout_code + slope[VW-1:0] : vtgt[VW-1:0];
        else if (vout_code > vtgt) vout_code = (vout_code - vtgt > slope) ? vout_code - slope[VW-1:0] : vtgt[VW-1:0];
      end
      tick = (cyc % 2 == 0);
    end
  endtask

  task automatic setv(input int v);
    vtgt = v; vout_code = v[VW-1:0];
  endtask

  task automatic rearm(input int v);
    enable = 1'b0; step(2);
    setv(v); vcmd_code = v[VW-1:0]; enable = 1'b1; step(10);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; tick = 1'b0;
    vout_code = '0; vcmd_code = '0; iout_code = '0;
    ov_margin = 10'd30; uv_margin = 10'd30; oc_limit = 10'd250;
    ov_resp = 8'd3; uv_resp = 8'd0; oc_resp = 8'd2;
    slew_min = 10'd20; slew_max = 10'd80;
    step(3);
    rst_n = 1'b1;
    step(2);
    // R8: reset state
    chk("R8 idle after reset", in_reg | in_trans | in_shut | ov_flag, 1'b0);

    // R8/R6: enable starts a ramp from zero to 400
    vcmd_code = 10'd400; vtgt = 400; slope = 10; enable = 1'b1;
    step(3);
    chk("R8 ramp after enable", in_trans, 1'b1);
    step(100);
    chk("R6 settled to regulate", in_reg, 1'b1);

    // R1/R4: short overshoot does not latch, full-length one does
    slope = 100;
    setv(440); step(4);
    chk("R4 short overshoot ignored", ov_flag, 1'b0);
    setv(400); step(2);
    setv(440); step(8);
    chk("R1 overvoltage latched", ov_flag, 1'b1);
    chk("R5 shutdown after overvoltage", in_shut, 1'b1);
    setv(400); step(4);
    chk("R5 shutdown held", in_shut & ov_flag, 1'b1);

    // R5: disable clears
    enable = 1'b0; step(2);
    chk("R5 flags cleared", ov_flag | in_shut, 1'b0);
    vcmd_code = 10'd400; enable = 1'b1; step(10);
    chk("R8 back to regulate", in_reg, 1'b1);

    // R2/R4: undervoltage with response 0 acts as 1
    setv(360); step(3);
    chk("R2 undervoltage latched", uv_flag & in_shut, 1'b1);

    // R3: overcurrent during a ramp to 500
    rearm(400);
    slope = 10; vtgt = 500; vcmd_code = 10'd500; iout_code = 10'd300;
    step(2);
    chk("R6 command change ramps", in_trans, 1'b1);
    chk("R3 not yet latched", oc_flag, 1'b0);
    step(6);
    chk("R3 overcurrent latched", oc_flag & in_shut, 1'b1);

    // R7: stalled output during ramp to 600
    iout_code = 10'd0;
    rearm(500);
    slope = 0; vtgt = 500; vcmd_code = 10'd600;
    step(14);
    chk("R7 slew fault latched", slew_flag & in_shut, 1'b1);

    // R9: overshoot while ramping down is not a fault
    slope = 10;
    rearm(600);
    vtgt = 300; vcmd_code = 10'd300;
    step(20);
    chk("R9 no overvoltage in ramp", ov_flag | in_shut, 1'b0);
    chk("R9 still ramping", in_trans, 1'b1);
    step(80);
    chk("R6 settled after ramp down", in_reg, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule